// File: doc/BRIEF.md
# FM Synthesizer Register Write Sequencer

This block is a synchronous bus master for a sound chip whose registers sit behind a multiplexed port with two banks. A client hands it one register write at a time: a bank bit, an 8-bit register number and an 8-bit value. The block turns that request into two timed bus cycles on the chip pins. The first cycle carries the register number and the second carries the value. Each cycle ends with a recovery gap long enough for the chip to absorb the byte.

Every interval is a whole number of system clocks. The counts come from the system and chip clock frequencies and from nanosecond timing parameters, so one parameter set retargets the block to a new board. A boot input starts the power-up sequence. That sequence pulses the chip's initial-clear line, waits one recovery, and then writes the mode register to select either the extended mode or the compatibility mode.

Top module: `fmreg_write_seq`

## Requirements
- R1: After reset, and whenever the block is idle, the outputs are at rest: chip select, write strobe, initial-clear, bank line and port line all high, the data bus 0x00, ready high and boot-done low.
- R2: A register write consists of two bus cycles, back to back. The bank line carries the request's bank bit in both cycles. In the first cycle the port line is 0 and the bus carries the register number. In the second cycle the port line is 1 and the bus carries the value.
- R3: Each bus cycle runs in five phases, in this order. (1) Setup: the lines are driven and both strobes are high. (2) Strobe: chip select and write strobe are low and the byte is on the bus. (3) Release: write strobe is high for one clock while chip select is still low. (4) Hold: both strobes are high and the byte is still driven. (5) Recovery: the bus returns to 0x00.
- R4: A nanosecond interval lasts floor(ns × f_sys / 1e9) clocks, but never less than 1. Setup uses the address setup time. The strobe phase uses the largest of the data setup time, the write pulse width and the chip-select width. Hold uses the data hold time. Recovery lasts 32 × (f_sys / f_chip) clocks, where the ratio is an integer quotient.
- R5: A request is accepted on a clock edge where valid and ready are both high. Ready then stays low for exactly two bus-cycle lengths. A request that is presented while ready is low is ignored until ready returns.
- R6: Boot first drives initial-clear low for 400 × (f_sys / f_chip) clocks and then holds it high for one recovery interval. Chip select stays high throughout. Boot then writes bank 1, register 0x05 with the value 0x01 for the extended mode or 0x00 for the compatibility mode.
- R7: Boot-done is high for exactly one clock: the last clock of the mode write's second recovery interval.
- R8: If boot and a valid request arrive on the same idle edge, boot runs first. The request is served after boot completes, provided valid is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_bank_i | input | 1 | Target bank of the request |
| req_addr_i | input | 8 | Register number |
| req_data_i | input | 8 | Register value |
| boot_i | input | 1 | Start the clear-then-mode sequence |
| boot_mode_i | input | 1 | 1 selects the extended mode, 0 the compatibility mode |
| boot_done_o | output | 1 | One-clock pulse when the mode write completes |
| chip_a1_o | output | 1 | Bank line to the chip |
| chip_a0_o | output | 1 | Port line: 0 for the register number, 1 for the value |
| chip_cs_n_o | output | 1 | Chip select, active low |
| chip_wr_n_o | output | 1 | Write strobe, active low |
| chip_ic_n_o | output | 1 | Initial-clear, active low |
| chip_data_o | output | 8 | Data bus to the chip |

## Verification
The boot command and a register write request can both be raised on the same idle edge. The bench drives them together on one falling edge and checks the result clock by clock. It expects initial-clear to go low at the first sample. It expects the full mode write to follow, with no trace of the request on the pins. It then keeps valid high and expects the request to be accepted on the edge right after ready returns, with its complete two-cycle waveform. A second overlap arises when a new request lands while a write is in progress. The bench checks that the changed fields stay out of the running write and are written only after it ends.

// File: rtl/fmw_pkg.sv
`timescale 1ns/1ps
package fmw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RELEASE,
        PH_HOLD,
        PH_RECOVER
    } bus_phase_e;

    typedef enum logic [1:0] {
        CL_IDLE,
        CL_LOW,
        CL_WAIT
    } clear_phase_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WR_ADDR,
        SQ_WR_DATA,
        SQ_CLEAR,
        SQ_BOOT_ADDR,
        SQ_BOOT_DATA
    } seq_state_e;

    localparam logic       MODE_BANK = 1'b1;
    localparam logic [7:0] MODE_REG  = 8'h05;

    // Converts nanoseconds to whole system clocks, rounding down and never returning less than one.
    function automatic int unsigned ns_to_clk(longint unsigned ns, longint unsigned hz);
        longint unsigned c;
        c = (ns * hz) / 64'd1000000000;
        if (c == 64'd0) c = 64'd1;
        return 32'(c);
    endfunction

    function automatic int unsigned at_least_one(int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fmw_interval_timer.sv
`timescale 1ns/1ps
module fmw_interval_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == '0);

    // R4: a loaded length of N produces N-1 on the following clock
    p_load_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && len_i != '0) |=> (cnt_q == $past(len_i) - CNT_W'(1)));
endmodule

// File: rtl/fmw_bus_cycle.sv
`timescale 1ns/1ps
module fmw_bus_cycle
    import fmw_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned N_AS  = 1,
    parameter int unsigned N_ST  = 1,
    parameter int unsigned N_WDH = 1,
    parameter int unsigned N_REC = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       bank_i,
    input  logic       port_i,
    input  logic [7:0] byte_i,
    output logic       done_o,
    output logic       a1_o,
    output logic       a0_o,
    output logic       cs_n_o,
    output logic       wr_n_o,
    output logic [7:0] data_o
);
    typedef struct packed {
        bus_phase_e phase;
        logic       bank;
        logic       port;
        logic [7:0] dbyte;
    } bus_state_t;

    bus_state_t       state_d, state_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_last;

    fmw_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .last_o (tmr_last)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_len  = CNT_W'(1);
        unique case (state_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    state_d.phase = PH_SETUP;
                    state_d.bank  = bank_i;
                    state_d.port  = port_i;
                    state_d.dbyte = byte_i;
                    tmr_load      = 1'b1;
                    tmr_len       = CNT_W'(N_AS);
                end
            end
            PH_SETUP: begin
                if (tmr_last) begin
                    state_d.phase = PH_STROBE;
                    tmr_load      = 1'b1;
                    tmr_len       = CNT_W'(N_ST);
                end
            end
            PH_STROBE: begin
                if (tmr_last) begin
                    state_d.phase = PH_RELEASE;
                    tmr_load      = 1'b1;
                    tmr_len       = CNT_W'(1);
                end
            end
            PH_RELEASE: begin
                if (tmr_last) begin
                    state_d.phase = PH_HOLD;
                    tmr_load      = 1'b1;
                    tmr_len       = CNT_W'(N_WDH);
                end
            end
            PH_HOLD: begin
                if (tmr_last) begin
                    state_d.phase = PH_RECOVER;
                    tmr_load      = 1'b1;
                    tmr_len       = CNT_W'(N_REC);
                end
            end
            PH_RECOVER: begin
                if (tmr_last) begin
                    if (start_i) begin
                        state_d.phase = PH_SETUP;
                        state_d.bank  = bank_i;
                        state_d.port  = port_i;
                        state_d.dbyte = byte_i;
                        tmr_load      = 1'b1;
                        tmr_len       = CNT_W'(N_AS);
                    end else begin
                        state_d.phase = PH_IDLE;
                    end
                end
            end
            default: state_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.phase <= PH_IDLE;
            state_q.bank  <= 1'b0;
            state_q.port  <= 1'b0;
            state_q.dbyte <= 8'h00;
        end else begin
            state_q <= state_d;
        end
    end

    assign done_o = (state_q.phase == PH_RECOVER) && tmr_last;
    assign a1_o   = (state_q.phase == PH_IDLE) ? 1'b1 : state_q.bank;
    assign a0_o   = (state_q.phase == PH_IDLE) ? 1'b1 : state_q.port;
    assign cs_n_o = !((state_q.phase == PH_STROBE) || (state_q.phase == PH_RELEASE));
    assign wr_n_o = !(state_q.phase == PH_STROBE);
    assign data_o = ((state_q.phase == PH_STROBE) || (state_q.phase == PH_RELEASE) ||
                     (state_q.phase == PH_HOLD)) ? state_q.dbyte : 8'h00;

    p_wr_within_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_n_o |-> !cs_n_o);
    p_cs_after_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wr_n_o) |-> !cs_n_o);
    p_lines_steady_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_n_o |=> (cs_n_o || ($stable(a0_o) && $stable(a1_o) && $stable(data_o))));
endmodule

// File: rtl/fmw_clear_pulse.sv
`timescale 1ns/1ps
module fmw_clear_pulse
    import fmw_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned N_ICW = 1,
    parameter int unsigned N_REC = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic ic_n_o,
    output logic done_o
);
    clear_phase_e     phase_d, phase_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_last;

    fmw_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .last_o (tmr_last)
    );

    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_len  = CNT_W'(1);
        unique case (phase_q)
            CL_IDLE: begin
                if (start_i) begin
                    phase_d  = CL_LOW;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(N_ICW);
                end
            end
            CL_LOW: begin
                if (tmr_last) begin
                    phase_d  = CL_WAIT;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(N_REC);
                end
            end
            CL_WAIT: begin
                if (tmr_last) phase_d = CL_IDLE;
            end
            default: phase_d = CL_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) phase_q <= CL_IDLE;
        else         phase_q <= phase_d;
    end

    assign ic_n_o = (phase_q != CL_LOW);
    assign done_o = (phase_q == CL_WAIT) && tmr_last;

    p_clear_starts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && phase_q == CL_IDLE) |=> !ic_n_o);
endmodule

// File: rtl/fmreg_write_seq.sv
`timescale 1ns/1ps
module fmreg_write_seq
    import fmw_pkg::*;
#(
    parameter int unsigned SYS_HZ        = 50000000,
    parameter int unsigned CHIP_HZ       = 14318180,
    parameter int unsigned T_AS_NS       = 10,
    parameter int unsigned T_WDS_NS      = 10,
    parameter int unsigned T_WW_NS       = 100,
    parameter int unsigned T_CSW_NS      = 100,
    parameter int unsigned T_WDH_NS      = 20,
    parameter int unsigned REC_CHIP_CLKS = 32,
    parameter int unsigned ICW_CHIP_CLKS = 400
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       req_valid_i,
    output logic       req_ready_o,
    input  logic       req_bank_i,
    input  logic [7:0] req_addr_i,
    input  logic [7:0] req_data_i,
    input  logic       boot_i,
    input  logic       boot_mode_i,
    output logic       boot_done_o,
    output logic       chip_a1_o,
    output logic       chip_a0_o,
    output logic       chip_cs_n_o,
    output logic       chip_wr_n_o,
    output logic       chip_ic_n_o,
    output logic [7:0] chip_data_o
);
    localparam int unsigned RATIO = SYS_HZ / CHIP_HZ;
    localparam int unsigned N_AS  = ns_to_clk(T_AS_NS, SYS_HZ);
    localparam int unsigned N_ST  = max2(ns_to_clk(T_WDS_NS, SYS_HZ),
                                    max2(ns_to_clk(T_WW_NS, SYS_HZ), ns_to_clk(T_CSW_NS, SYS_HZ)));
    localparam int unsigned N_WDH = ns_to_clk(T_WDH_NS, SYS_HZ);
    localparam int unsigned N_REC = at_least_one(REC_CHIP_CLKS * RATIO);
    localparam int unsigned N_ICW = at_least_one(ICW_CHIP_CLKS * RATIO);
    localparam int unsigned N_MAX = max2(max2(N_ICW, N_REC), max2(max2(N_AS, N_ST), N_WDH));
    localparam int unsigned CNT_W = $clog2(N_MAX + 1);

    typedef struct packed {
        seq_state_e st;
        logic       bank;
        logic [7:0] value;
        logic       mode;
    } seq_t;

    seq_t       seq_d, seq_q;
    logic       bus_start, bus_bank, bus_port, bus_done;
    logic [7:0] bus_byte;
    logic       clr_start, clr_done;
    logic       done_pulse;

    fmw_bus_cycle #(
        .CNT_W (CNT_W),
        .N_AS  (N_AS),
        .N_ST  (N_ST),
        .N_WDH (N_WDH),
        .N_REC (N_REC)
    ) u_bus (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (bus_start),
        .bank_i  (bus_bank),
        .port_i  (bus_port),
        .byte_i  (bus_byte),
        .done_o  (bus_done),
        .a1_o    (chip_a1_o),
        .a0_o    (chip_a0_o),
        .cs_n_o  (chip_cs_n_o),
        .wr_n_o  (chip_wr_n_o),
        .data_o  (chip_data_o)
    );

    fmw_clear_pulse #(
        .CNT_W (CNT_W),
        .N_ICW (N_ICW),
        .N_REC (N_REC)
    ) u_clear (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (clr_start),
        .ic_n_o  (chip_ic_n_o),
        .done_o  (clr_done)
    );

    always_comb begin
        seq_d      = seq_q;
        bus_start  = 1'b0;
        bus_bank   = 1'b0;
        bus_port   = 1'b0;
        bus_byte   = 8'h00;
        clr_start  = 1'b0;
        done_pulse = 1'b0;
        unique case (seq_q.st)
            SQ_IDLE: begin
                if (boot_i) begin
                    clr_start  = 1'b1;
                    seq_d.st   = SQ_CLEAR;
                    seq_d.mode = boot_mode_i;
                end else if (req_valid_i) begin
                    bus_start   = 1'b1;
                    bus_bank    = req_bank_i;
                    bus_port    = 1'b0;
                    bus_byte    = req_addr_i;
                    seq_d.st    = SQ_WR_ADDR;
                    seq_d.bank  = req_bank_i;
                    seq_d.value = req_data_i;
                end
            end
            SQ_WR_ADDR: begin
                if (bus_done) begin
                    bus_start = 1'b1;
                    bus_bank  = seq_q.bank;
                    bus_port  = 1'b1;
                    bus_byte  = seq_q.value;
                    seq_d.st  = SQ_WR_DATA;
                end
            end
            SQ_WR_DATA: begin
                if (bus_done) seq_d.st = SQ_IDLE;
            end
            SQ_CLEAR: begin
                if (clr_done) begin
                    bus_start = 1'b1;
                    bus_bank  = MODE_BANK;
                    bus_port  = 1'b0;
                    bus_byte  = MODE_REG;
                    seq_d.st  = SQ_BOOT_ADDR;
                end
            end
            SQ_BOOT_ADDR: begin
                if (bus_done) begin
                    bus_start = 1'b1;
                    bus_bank  = MODE_BANK;
                    bus_port  = 1'b1;
                    bus_byte  = {7'b0, seq_q.mode};
                    seq_d.st  = SQ_BOOT_DATA;
                end
            end
            SQ_BOOT_DATA: begin
                if (bus_done) begin
                    done_pulse = 1'b1;
                    seq_d.st   = SQ_IDLE;
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q.st    <= SQ_IDLE;
            seq_q.bank  <= 1'b0;
            seq_q.value <= 8'h00;
            seq_q.mode  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready_o = (seq_q.st == SQ_IDLE) && !boot_i;
    assign boot_done_o = done_pulse;

    p_busy_after_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=> !req_ready_o);
    p_no_select_in_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chip_ic_n_o |-> (chip_cs_n_o && chip_wr_n_o));
    p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        boot_done_o |=> !boot_done_o);
    p_boot_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (boot_i && req_valid_i && seq_q.st == SQ_IDLE) |=> (!chip_ic_n_o && chip_cs_n_o));
endmodule

// File: tb/fmreg_write_seq_bench.sv
`timescale 1ns/1ps
module fmreg_write_seq_bench;
    localparam longint SYS  = 50000000;
    localparam longint CHIP = 25000000;

    function automatic int clk_of(longint ns);
        longint c;
        c = (ns * SYS) / 64'd1000000000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    localparam int RATIO = int'(SYS / CHIP);
    localparam int AS    = clk_of(10);
    localparam int ST_A  = (clk_of(10) > clk_of(100)) ? clk_of(10) : clk_of(100);
    localparam int ST    = (ST_A > clk_of(100)) ? ST_A : clk_of(100);
    localparam int WDH   = clk_of(20);
    localparam int REC   = 32 * RATIO;
    localparam int ICW   = 400 * RATIO;
    localparam int L     = AS + ST + 1 + WDH + REC;
    localparam logic [14:0] IDLE_V = {7'b1111110, 8'h00};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid = 1'b0, bank = 1'b0, boot = 1'b0, mode = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic ready, done, a1, a0, cs_n, wr_n, ic_n;
    logic [7:0] bus;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    fmreg_write_seq #(.SYS_HZ(32'(SYS)), .CHIP_HZ(32'(CHIP))) u_fmreg_write_seq (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
        .req_bank_i(bank), .req_addr_i(addr), .req_data_i(wdata),
        .boot_i(boot), .boot_mode_i(mode), .boot_done_o(done),
        .chip_a1_o(a1), .chip_a0_o(a0), .chip_cs_n_o(cs_n), .chip_wr_n_o(wr_n),
        .chip_ic_n_o(ic_n), .chip_data_o(bus)
    );

    function automatic logic [14:0] pins();
        return {a1, a0, cs_n, wr_n, ic_n, ready, done, bus};
    endfunction

    // Bit order: a1 a0 cs_n wr_n ic_n ready done data[7:0]
    function automatic logic [14:0] exp_bus(int t, logic bk, logic [7:0] ra, logic [7:0] rv);
        logic [14:0] v;
        logic        port;
        int          tt;
        logic [7:0]  b;
        port = (t >= L);
        tt   = port ? t - L : t;
        b    = port ? rv : ra;
        v    = {bk, port, 5'b11100, 8'h00};
        if (tt < AS) begin
        end else if (tt < AS + ST) begin
            v[12] = 1'b0; v[11] = 1'b0; v[7:0] = b;
        end else if (tt == AS + ST) begin
            v[12] = 1'b0; v[7:0] = b;
        end else if (tt < AS + ST + 1 + WDH) begin
            v[7:0] = b;
        end
        return v;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expects valid already high at a falling edge while ready is high.
    task automatic verify_write(logic bk, logic [7:0] ra, logic [7:0] rv, bit alt,
                                logic [7:0] alt_a, logic [7:0] alt_v);
        int bad = 0;
        int wr_low = 0;
        logic [14:0] fa = '0, fe = '0, g, e;
        logic [14:0] s_addr = '0, s_data = '0;
        @(posedge clk);
        for (int t = 0; t < 2 * L; t++) begin
            @(negedge clk);
            if (t == 0) begin
                if (alt) begin addr = alt_a; wdata = alt_v; end
                else valid = 1'b0;
            end
            g = pins();
            e = exp_bus(t, bk, ra, rv);
            if (!wr_n) wr_low++;
            if (t == AS) s_addr = g;
            if (t == L + AS) s_data = g;
            if (g !== e && bad == 0) begin fa = g; fe = e; end
            if (g !== e) bad++;
        end
        check(bad == 0, "R3", "write waveform phases", 32'(fa), 32'(fe));
        check(s_addr === exp_bus(AS, bk, ra, rv), "R2", "address cycle lines", 32'(s_addr), 32'(exp_bus(AS, bk, ra, rv)));
        check(s_data === exp_bus(L + AS, bk, ra, rv), "R2", "value cycle lines", 32'(s_data), 32'(exp_bus(L + AS, bk, ra, rv)));
        check(wr_low == 2 * ST, "R4", "strobe clocks per write", 32'(wr_low), 32'(2 * ST));
        @(negedge clk);
        check(pins() === IDLE_V, "R5", "ready back after two cycles", 32'(pins()), 32'(IDLE_V));
    endtask

    task automatic run_write(logic bk, logic [7:0] ra, logic [7:0] rv);
        bank = bk; addr = ra; wdata = rv; valid = 1'b1;
        verify_write(bk, ra, rv, 1'b0, 8'h00, 8'h00);
    endtask

    task automatic run_boot(logic md, bit with_req);
        int bad = 0;
        int low = 0;
        int pulses = 0;
        int done_at = -1;
        int tb = ICW + REC + 2 * L;
        logic [14:0] fa = '0, fe = '0, g, e;
        boot = 1'b1; mode = md;
        if (with_req) begin valid = 1'b1; bank = 1'b0; addr = 8'h3C; wdata = 8'hC3; end
        @(posedge clk);
        for (int t = 0; t < tb; t++) begin
            @(negedge clk);
            if (t == 0) boot = 1'b0;
            g = pins();
            if (t < ICW) e = {4'b1111, 3'b000, 8'h00};
            else if (t < ICW + REC) e = {4'b1111, 3'b100, 8'h00};
            else begin
                e = exp_bus(t - ICW - REC, 1'b1, 8'h05, {7'b0, md});
                e[8] = (t == tb - 1);
            end
            if (!ic_n) low++;
            if (done) begin pulses++; done_at = t; end
            if (g !== e && bad == 0) begin fa = g; fe = e; end
            if (g !== e) bad++;
        end
        check(bad == 0, "R6", "boot waveform", 32'(fa), 32'(fe));
        check(low == ICW, "R6", "initial-clear low clocks", 32'(low), 32'(ICW));
        check(pulses == 1 && done_at == tb - 1, "R7", "boot-done pulse", 32'(done_at), 32'(tb - 1));
        @(negedge clk);
        check(pins() === IDLE_V, "R1", "idle after boot", 32'(pins()), 32'(IDLE_V));
        if (with_req) verify_write(1'b0, 8'h3C, 8'hC3, 1'b0, 8'h00, 8'h00); // R8
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(pins() === IDLE_V, "R1", "levels in reset", 32'(pins()), 32'(IDLE_V));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(pins() === IDLE_V, "R1", "levels after reset", 32'(pins()), 32'(IDLE_V));
        // Sweep walking-one register numbers and inverted values over both banks
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 8; i++) run_write(1'(b), 8'(1 << i), ~8'(1 << i));
            run_write(1'(b), 8'h00, 8'hFF);
            run_write(1'(b), 8'hFF, 8'h00);
        end
        // R5: fields change while busy; must not disturb the running write, then be served
        bank = 1'b1; addr = 8'hA5; wdata = 8'h5A; valid = 1'b1;
        verify_write(1'b1, 8'hA5, 8'h5A, 1'b1, 8'h96, 8'h69);
        verify_write(1'b1, 8'h96, 8'h69, 1'b0, 8'h00, 8'h00);
        run_boot(1'b1, 1'b0);
        run_boot(1'b0, 1'b0);
        // R8: boot and a request on the same edge
        run_boot(1'b1, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule